// File: doc/BRIEF.md
# Remote Terminal Message Sequencer

This block controls one message at a time for a command/response serial-bus remote terminal. It sits after the word decoder and has no part in line coding or bus timing. A command strobe arrives at the parity midpoint of a validated command word. The strobe carries the direction, the subaddress and the word count. After a fixed number of clocks the block samples two active-low inputs from the host subsystem, busy and illegal, and from them sets the busy and message-error flags of the status reply.

On a transmit message, a legal and idle host is read once per data word. Each read is preceded by its own DMA request/grant handshake. When the host is busy or the command is illegal, only a status request is made. On a receive message, every incoming data word starts a handshake, and each granted handshake is followed by a write strobe. This still happens when the host is busy. A handshake that runs out of time drops only that word and marks the message. When a normal receive message is complete, correct and fully written, a two-clock active-low good-block pulse is produced. Malformed receive traffic sends the block back to idle without a reply.

Top module: `rt_msg_seq`

## Requirements
- R1: `busy_n` and `illegal_n` are sampled at the single rising edge exactly `SAMPLE_DLY` cycles after the edge that accepts `cmd_stb`. A low level at that edge sets `sts_busy` / `sts_merr` to 1 and a high level sets it to 0. Levels at other edges have no effect. For a transmit command, `sts_send` is high for the one cycle that follows the sampling edge.
- R2: A transmit command sampled busy or illegal gives exactly one `sts_send` pulse. It raises no `dma_req` and gives no `tx_stb`.
- R3: A legal, non-busy transmit command asks for N data words and runs one handshake per word, each after `sts_send`. For a normal subaddress, N is the word-count field, with 0 meaning 32. For each grant, `rd_stb` is high for the next cycle, and one cycle after that `tx_stb` presents the `rd_data` value taken while `rd_stb` was high.
- R4: In a receive message, each `rx_word_stb` raises `dma_req` in the next cycle, unless the command was sampled illegal. A grant is answered one cycle later by a one-cycle `wr_stb` that carries that word's `rx_data`. The word count follows the same rule as in R3.
- R5: If no grant arrives while `dma_req` has been high for `HS_TIMEOUT` cycles, that word is dropped and `sts_xerr` becomes 1. The remaining words are still handled, and `sts_send` is still given.
- R6: `gbr_n` goes low for exactly two cycles, starting one cycle after `msg_end`. This happens only for a receive to a normal subaddress that got exactly N words, was not illegal and had no timeout. Busy does not block it.
- R7: Subaddress 0 or 31 is a mode code. It carries one data word if bit 4 of the word-count field is 1 and none otherwise. It never produces a good-block pulse.
- R8: A receive is abandoned, with no `sts_send` and no `gbr_n` pulse, in three cases: `rx_word_bad` arrives, a word arrives after N words, or `msg_end` arrives before N words.
- R9: A new `cmd_stb` ends the message in progress. `dma_req` drops and `sts_xerr` is cleared on the accepting edge.
- R10: During reset `dma_req`, `rd_stb`, `wr_stb`, `tx_stb` and `sts_send` are 0, `gbr_n` is 1 and all status flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_stb | input | 1 | Valid command word, at its parity midpoint |
| cmd_tx | input | 1 | 1 = terminal transmits, 0 = terminal receives |
| cmd_sa | input | 5 | Subaddress field |
| cmd_wc | input | 5 | Word count / mode field |
| busy_n | input | 1 | Host busy, active low |
| illegal_n | input | 1 | Host rejects command, active low |
| rx_word_stb | input | 1 | Valid received data word |
| rx_word_bad | input | 1 | Invalid received word |
| rx_data | input | WORD_W | Received data word |
| msg_end | input | 1 | Bus went quiet after the message |
| dma_req | output | 1 | Handshake request to host |
| dma_gnt | input | 1 | Handshake grant from host |
| wr_stb | output | 1 | Write cycle to host |
| wr_data | output | WORD_W | Write data |
| rd_stb | output | 1 | Read cycle from host |
| rd_data | input | WORD_W | Read data from host |
| tx_stb | output | 1 | Data word ready for the encoder |
| tx_data | output | WORD_W | Data word to transmit |
| sts_send | output | 1 | Request to transmit the status word |
| sts_busy | output | 1 | Busy flag of the status word |
| sts_merr | output | 1 | Message-error flag of the status word |
| sts_xerr | output | 1 | Sticky handshake-timeout flag of this message |
| gbr_n | output | 1 | Good-block pulse, active low |

## Verification
An error in the sampling counter moves the busy and error flags away from the level present at the sampling edge. This shows up as soon as `SAMPLE_DLY` cycles after the command, because the bench holds the opposite levels on both inputs at every other edge. A bad word counter or bad handshake state shows at the ports within one message: a `tx_stb` or `wr_stb` is missing or extra, a data value is wrong, or the good-block pulse appears or fails to appear at the end of the message. A stuck handshake timer shows within `HS_TIMEOUT` cycles, as a word written that the host never granted or as a timeout flag that is missing.

// File: rtl/rt_msg_seq.sv
module rt_msg_seq #(
  parameter int SAMPLE_DLY = 500,
  parameter int HS_TIMEOUT = 64,
  parameter int WORD_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_stb,
  input  logic              cmd_tx,
  input  logic [4:0]        cmd_sa,
  input  logic [4:0]        cmd_wc,
  input  logic              busy_n,
  input  logic              illegal_n,
  input  logic              rx_word_stb,
  input  logic              rx_word_bad,
  input  logic [WORD_W-1:0] rx_data,
  input  logic              msg_end,
  output logic              dma_req,
  input  logic              dma_gnt,
  output logic              wr_stb,
  output logic [WORD_W-1:0] wr_data,
  output logic              rd_stb,
  input  logic [WORD_W-1:0] rd_data,
  output logic              tx_stb,
  output logic [WORD_W-1:0] tx_data,
  output logic              sts_send,
  output logic              sts_busy,
  output logic              sts_merr,
  output logic              sts_xerr,
  output logic              gbr_n
);
  localparam int DW = $clog2(SAMPLE_DLY + 1);
  localparam int HW = $clog2(HS_TIMEOUT + 1);

  typedef enum logic [2:0] {S_IDLE, S_DLY, S_RX, S_RXHS, S_TXHS, S_TXRD} st_t;

  st_t               st;
  logic [DW-1:0]     dly;
  logic [HW-1:0]     hs;
  logic [5:0]        wcnt, need;
  logic              is_tx, is_mode, bsy, ill, xerr;
  logic [1:0]        gbr_cnt;
  logic [WORD_W-1:0] hold;

  wire       mode_w = (cmd_sa == 5'd0) || (cmd_sa == 5'd31);
  wire [5:0] need_w = mode_w ? {5'd0, cmd_wc[4]} :
                      (cmd_wc == 5'd0) ? 6'd32 : {1'b0, cmd_wc};
  wire       last   = (wcnt + 6'd1) == need;
  wire       hs_to  = hs == HW'(HS_TIMEOUT - 1);

  assign dma_req  = (st == S_RXHS) || (st == S_TXHS);
  assign rd_stb   = st == S_TXRD;
  assign gbr_n    = gbr_cnt == 2'd0;
  assign sts_busy = bsy;
  assign sts_merr = ill;
  assign sts_xerr = xerr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;  dly <= '0;  hs <= '0;  wcnt <= '0;  need <= '0;
      is_tx <= 1'b0; is_mode <= 1'b0; bsy <= 1'b0; ill <= 1'b0; xerr <= 1'b0;
      gbr_cnt <= '0; hold <= '0; wr_data <= '0; tx_data <= '0;
      wr_stb <= 1'b0; tx_stb <= 1'b0; sts_send <= 1'b0;
    end else begin
      wr_stb   <= 1'b0;
      tx_stb   <= 1'b0;
      sts_send <= 1'b0;
      if (gbr_cnt != 2'd0) gbr_cnt <= gbr_cnt - 2'd1;

      if (cmd_stb) begin
        st      <= S_DLY;
        dly     <= DW'(SAMPLE_DLY - 1);
        is_tx   <= cmd_tx;
        is_mode <= mode_w;
        need    <= need_w;
        wcnt    <= '0;
        xerr    <= 1'b0;
      end else begin
        case (st)
          S_DLY:
            if (dly != '0) dly <= dly - 1'b1;
            else begin
              bsy <= !busy_n;
              ill <= !illegal_n;
              hs  <= '0;
              if (is_tx) begin
                sts_send <= 1'b1;
                st <= (busy_n && illegal_n && need != 6'd0) ? S_TXHS : S_IDLE;
              end else st <= S_RX;
            end
          S_RX:
            if (rx_word_bad) st <= S_IDLE;
            else if (rx_word_stb) begin
              if (wcnt == need) st <= S_IDLE;
              else begin
                wcnt <= wcnt + 6'd1;
                hold <= rx_data;
                hs   <= '0;
                if (!ill) st <= S_RXHS;
              end
            end else if (msg_end) begin
              st <= S_IDLE;
              if (wcnt == need) begin
                sts_send <= 1'b1;
                if (!is_mode && !ill && !xerr) gbr_cnt <= 2'd2;
              end
            end
          S_RXHS:
            if (rx_word_bad) st <= S_IDLE;
            else if (dma_gnt) begin
              wr_stb  <= 1'b1;
              wr_data <= hold;
              st      <= S_RX;
            end else if (hs_to) begin
              xerr <= 1'b1;
              st   <= S_RX;
            end else hs <= hs + 1'b1;
          S_TXHS:
            if (dma_gnt) st <= S_TXRD;
            else if (hs_to) begin
              xerr <= 1'b1;
              wcnt <= wcnt + 6'd1;
              hs   <= '0;
              if (last) st <= S_IDLE;
            end else hs <= hs + 1'b1;
          S_TXRD: begin
            tx_stb  <= 1'b1;
            tx_data <= rd_data;
            wcnt    <= wcnt + 6'd1;
            hs      <= '0;
            st      <= last ? S_IDLE : S_TXHS;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/rt_msg_seq_chk.sv
module rt_msg_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic dma_req,
  input logic dma_gnt,
  input logic wr_stb,
  input logic rd_stb,
  input logic tx_stb,
  input logic sts_send,
  input logic gbr_n
);
  AST_GNT_ENDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && dma_gnt) |=> !dma_req); // R4
  AST_WR_NEEDS_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(dma_req && dma_gnt)); // R4
  AST_TX_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_stb |-> $past(rd_stb)); // R3
  AST_GBR_WITH_STS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gbr_n) |-> sts_send); // R6
  AST_GBR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gbr_n) |=> !gbr_n); // R6
  AST_GBR_TWO_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    (!gbr_n && !$past(gbr_n)) |=> gbr_n); // R6
endmodule

bind rt_msg_seq rt_msg_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .dma_req(dma_req), .dma_gnt(dma_gnt),
  .wr_stb(wr_stb), .rd_stb(rd_stb), .tx_stb(tx_stb),
  .sts_send(sts_send), .gbr_n(gbr_n)
);

// File: tb/rt_msg_seq_tb.sv
module rt_msg_seq_tb_top;
  localparam int D = 6;
  localparam int T = 5;
  localparam int LONG = T + 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_stb = 0, cmd_tx = 0, busy_n = 1, illegal_n = 1;
  logic [4:0] cmd_sa = 0, cmd_wc = 0;
  logic rx_word_stb = 0, rx_word_bad = 0, msg_end = 0, dma_gnt = 0;
  logic [15:0] rx_data = 0, rd_data = 0;
  logic dma_req, wr_stb, rd_stb, tx_stb, sts_send, sts_busy, sts_merr, sts_xerr, gbr_n;
  logic [15:0] wr_data, tx_data;

  always #2 clk = ~clk;

  rt_msg_seq #(.SAMPLE_DLY(D), .HS_TIMEOUT(T), .WORD_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .cmd_tx(cmd_tx), .cmd_sa(cmd_sa),
    .cmd_wc(cmd_wc), .busy_n(busy_n), .illegal_n(illegal_n), .rx_word_stb(rx_word_stb),
    .rx_word_bad(rx_word_bad), .rx_data(rx_data), .msg_end(msg_end), .dma_req(dma_req),
    .dma_gnt(dma_gnt), .wr_stb(wr_stb), .wr_data(wr_data), .rd_stb(rd_stb),
    .rd_data(rd_data), .tx_stb(tx_stb), .tx_data(tx_data), .sts_send(sts_send),
    .sts_busy(sts_busy), .sts_merr(sts_merr), .sts_xerr(sts_xerr), .gbr_n(gbr_n));

  int n_chk = 0, n_fail = 0, cyc = 0;
  int lat_tab[64];
  int lat_idx = 0, wait_c = 0, rd_cnt = 0;
  int wr_log[64], tx_log[64];
  int wr_n = 0, tx_n = 0, sts_cnt = 0, sts_cyc = 0, tx_first = 0, req_rises = 0;
  int gbr_runs = 0, gbr_low = 0, gbr_len = 0, gbr_first = 0, end_cyc = 0, cmd_cyc = 0;
  logic prev_req = 0;

  always @(posedge clk) cyc++;

  // host model: grants after lat_tab[] cycles, supplies read data
  always @(negedge clk) begin
    dma_gnt = 1'b0;
    if (!dma_req) wait_c = 0;
    else if (lat_tab[lat_idx] == wait_c) begin dma_gnt = 1'b1; lat_idx++; wait_c = 0; end
    else if (wait_c == T - 1) begin lat_idx++; wait_c = 0; end
    else wait_c++;
    if (rd_stb) begin rd_data = 16'hA000 + 16'(rd_cnt); rd_cnt++; end
  end

  always @(negedge clk) if (rst_n) begin
    if (wr_stb) begin wr_log[wr_n] = int'(wr_data); wr_n++; end
    if (tx_stb) begin if (tx_n == 0) tx_first = cyc; tx_log[tx_n] = int'(tx_data); tx_n++; end
    if (sts_send) begin sts_cnt++; sts_cyc = cyc; end
    if (dma_req && !prev_req) req_rises++;
    prev_req = dma_req;
    if (!gbr_n) begin if (gbr_low == 0) gbr_first = cyc; gbr_low++; end
    else if (gbr_low != 0) begin gbr_runs++; gbr_len = gbr_low; gbr_low = 0; end
  end

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic clear_logs();
    @(posedge clk); #1;
    lat_idx = 0; wait_c = 0; rd_cnt = 0; wr_n = 0; tx_n = 0; sts_cnt = 0;
    req_rises = 0; gbr_runs = 0; gbr_low = 0; gbr_len = 0;
  endtask

  function automatic int need_of(input logic [4:0] sa, input logic [4:0] wc);
    if (sa == 5'd0 || sa == 5'd31) return int'(wc[4]);
    return (wc == 5'd0) ? 32 : int'(wc);
  endfunction

  // levels at the sampling edge are bn/iln; opposite levels everywhere else (R1)
  task automatic send_cmd(input logic tx, input logic [4:0] sa, input logic [4:0] wc,
                          input logic bn, input logic iln);
    @(negedge clk);
    cmd_stb = 1; cmd_tx = tx; cmd_sa = sa; cmd_wc = wc; busy_n = !bn; illegal_n = !iln;
    cmd_cyc = cyc;
    @(negedge clk); cmd_stb = 0;
    repeat (D - 1) @(negedge clk);
    busy_n = bn; illegal_n = iln;
    @(negedge clk);
    busy_n = !bn; illegal_n = !iln;
    chk(sts_busy == !bn, "R1", "sts_busy", int'(sts_busy), int'(!bn));
    chk(sts_merr == !iln, "R1", "sts_merr", int'(sts_merr), int'(!iln));
  endtask

  task automatic pulse_word(input bit bad, input logic [15:0] v);
    repeat (T + 4) @(negedge clk);
    rx_word_stb = !bad; rx_word_bad = bad; rx_data = v;
    @(negedge clk); rx_word_stb = 0; rx_word_bad = 0;
  endtask

  task automatic run_rx(input logic [4:0] sa, input logic [4:0] wc, input logic bn,
                        input logic iln, input int nwords, input int bad_at);
    int need = need_of(sa, wc);
    bit mode = (sa == 5'd0 || sa == 5'd31);
    bit abort = 0, xe = 0, gbr_exp;
    int exp_wr[64];
    int ne = 0;
    clear_logs();
    send_cmd(1'b0, sa, wc, bn, iln);
    for (int i = 0; i < nwords; i++) begin
      logic [15:0] v = 16'h5000 + 16'(i * 7) + 16'(cyc & 255);
      if (i == bad_at) begin pulse_word(1'b1, v); abort = 1; break; end
      pulse_word(1'b0, v);
      if (i == need) begin abort = 1; break; end
      if (iln) begin
        if (lat_tab[i] < T) begin exp_wr[ne] = int'(v); ne++; end else xe = 1;
      end
    end
    if (!abort && nwords != need) abort = 1;
    repeat (T + 4) @(negedge clk);
    msg_end = 1; end_cyc = cyc;
    @(negedge clk); msg_end = 0;
    repeat (6) @(negedge clk);
    gbr_exp = !abort && !mode && iln && !xe;
    chk(wr_n == ne, iln ? "R4" : "R4 illegal", "write count", wr_n, ne);
    for (int k = 0; k < ne && k < wr_n; k++)
      chk(wr_log[k] == exp_wr[k], "R4", "write data", wr_log[k], exp_wr[k]);
    chk(sts_cnt == int'(!abort), abort ? "R8" : "R5", "status requests", sts_cnt, int'(!abort));
    chk(gbr_runs == int'(gbr_exp), mode ? "R7" : "R6", "good-block pulses", gbr_runs, int'(gbr_exp));
    if (gbr_exp && gbr_runs == 1) begin
      chk(gbr_len == 2, "R6", "good-block width", gbr_len, 2);
      chk(gbr_first - end_cyc == 1, "R6", "good-block delay", gbr_first - end_cyc, 1);
    end
    if (!abort) chk(sts_xerr == xe, "R5", "sts_xerr", int'(sts_xerr), int'(xe));
  endtask

  task automatic run_tx(input logic [4:0] sa, input logic [4:0] wc, input logic bn, input logic iln);
    int need = need_of(sa, wc);
    bit xe = 0;
    int k = 0;
    clear_logs();
    send_cmd(1'b1, sa, wc, bn, iln);
    repeat (need * (T + 3) + 12) @(negedge clk);
    if (bn && iln) begin
      for (int i = 0; i < need; i++) if (lat_tab[i] < T) k++; else xe = 1;
      chk(req_rises >= int'(need != 0), "R3", "handshake started", req_rises, int'(need != 0));
    end else
      chk(req_rises == 0, "R2", "handshake on rejected transmit", req_rises, 0);
    chk(tx_n == k, (bn && iln) ? "R3" : "R2", "words sent", tx_n, k);
    for (int j = 0; j < k && j < tx_n; j++)
      chk(tx_log[j] == 32'hA000 + j, "R3", "sent data", tx_log[j], 32'hA000 + j);
    chk(sts_cnt == 1, "R2", "status requests", sts_cnt, 1);
    chk(sts_cyc - cmd_cyc == D + 1, "R1", "status timing", sts_cyc - cmd_cyc, D + 1);
    if (tx_n > 0) chk(tx_first > sts_cyc, "R3", "status before data", tx_first, sts_cyc + 1);
    chk(gbr_runs == 0, "R6", "good-block on transmit", gbr_runs, 0);
    chk(sts_xerr == xe, "R5", "sts_xerr", int'(sts_xerr), int'(xe));
  endtask

  task automatic set_lat(input int v);
    for (int i = 0; i < 64; i++) lat_tab[i] = v;
  endtask

  initial begin
    void'($urandom(32'd2718));
    set_lat(0);
    repeat (3) @(negedge clk);
    chk(!dma_req && !rd_stb && !wr_stb && !tx_stb && !sts_send, "R10", "strobes in reset",
        int'(dma_req | rd_stb | wr_stb | tx_stb | sts_send), 0);
    chk(gbr_n && !sts_busy && !sts_merr && !sts_xerr, "R10", "gbr_n/flags in reset",
        int'({gbr_n, sts_busy, sts_merr, sts_xerr}), 8);
    rst_n = 1;

    lat_tab[0] = 0; lat_tab[1] = 2; lat_tab[2] = T - 1;
    run_rx(5'd5, 5'd3, 1, 1, 3, -1);
    set_lat(1);  run_rx(5'd9, 5'd0, 1, 1, 32, -1);
    set_lat(0);  run_rx(5'd2, 5'd4, 0, 1, 4, -1);
    run_rx(5'd7, 5'd2, 1, 0, 2, -1);
    lat_tab[1] = LONG; run_rx(5'd3, 5'd3, 1, 1, 3, -1); set_lat(0);
    run_rx(5'd0, 5'd17, 1, 1, 1, -1);
    run_rx(5'd31, 5'd2, 1, 1, 0, -1);
    run_rx(5'd4, 5'd2, 1, 1, 3, -1);
    run_rx(5'd4, 5'd3, 1, 1, 2, -1);
    run_rx(5'd4, 5'd3, 1, 1, 3, 1);
    lat_tab[1] = 3; run_tx(5'd6, 5'd4, 1, 1);
    lat_tab[2] = LONG; run_tx(5'd6, 5'd4, 1, 1); set_lat(0);
    run_tx(5'd6, 5'd4, 0, 1);
    run_tx(5'd6, 5'd4, 1, 0);
    run_tx(5'd31, 5'd18, 1, 1);
    run_tx(5'd12, 5'd0, 1, 1);

    // R9: a new command cuts a transmit and clears the timeout flag
    set_lat(LONG);
    clear_logs();
    send_cmd(1'b1, 5'd3, 5'd4, 1, 1);
    repeat (T + 2) @(negedge clk);
    chk(sts_xerr == 1, "R5", "timeout flag on transmit", int'(sts_xerr), 1);
    set_lat(0);
    clear_logs();
    send_cmd(1'b0, 5'd2, 5'd1, 1, 1);
    chk(sts_xerr == 0, "R9", "timeout flag after new command", int'(sts_xerr), 0);
    chk(tx_n == 0, "R9", "words of cut transmit", tx_n, 0);
    pulse_word(1'b0, 16'h1234);
    repeat (T + 4) @(negedge clk);
    msg_end = 1; @(negedge clk); msg_end = 0;
    repeat (6) @(negedge clk);
    chk(wr_n == 1 && wr_log[0] == 32'h1234, "R9", "write after restart", wr_log[0], 32'h1234);
    chk(gbr_runs == 1, "R9", "good block after restart", gbr_runs, 1);

    for (int it = 0; it < 30; it++) begin
      logic [4:0] sa = 5'($urandom % 32);
      logic [4:0] wc = 5'($urandom % 32);
      logic bn = ($urandom % 5) != 0;
      logic iln = ($urandom % 5) != 0;
      int need = need_of(sa, wc);
      for (int i = 0; i < 64; i++) lat_tab[i] = (($urandom % 8) == 0) ? LONG : int'($urandom % T);
      if ($urandom % 2) run_tx(sa, wc, bn, iln);
      else begin
        int pick = int'($urandom % 6);
        if (pick == 0) run_rx(sa, wc, bn, iln, need + 1, -1);
        else if (pick == 1 && need > 0) run_rx(sa, wc, bn, iln, need, int'($urandom % need));
        else run_rx(sa, wc, bn, iln, need, -1);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule